// File: doc/BRIEF.md
# Sequential Ones Counter with Separate Control and Datapath

This block reports how many bits of an 8-bit operand word are set to 1. It is not a combinational tree. A small control state machine steers a datapath that holds two registers: a right-shifting copy of the operand and a tally. The state machine is kept apart from the datapath. Every register action that a state selects is applied at the clock edge that ends that state, not at the moment the state is entered.

While `start` is low, the block sits idle. On each clock it copies `operand` and holds the tally at zero. Once the synchronized `start` is seen high, the copy shifts right one place per clock and the bit shifted out is added to the tally. When the copy reaches zero, `done` rises and the tally holds until `start` is released. `start` passes through a two-flop synchronizer, so it may come from a slow or unrelated source. The reset is synchronous.

Top module: `bitcount_asmd`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle: after that edge `done` is 0 and `count` is 0.
- R2: While the synchronized `start` is low and the block is idle, `count` reads 0 and `done` reads 0.
- R3: When `done` is 1, `count` equals the number of 1 bits in the operand word captured on the last idle clock edge, a value from 0 to 8.
- R4: If `start` is raised just after clock edge 0 from idle, `done` first reads 1 after edge 4+k. Here k is one more than the index of the highest set bit of the captured word, and k is 0 for a zero word.
- R5: While `done` is 1 and `start` stays high, `done` stays 1 and `count` keeps its value, whatever `operand` does.
- R6: After `start` falls in the done state, `done` reads 0 after the third clock edge, and `count` reads 0 after the fourth.
- R7: Changes on `operand` after the count has begun have no effect on the final `count`.
- R8: A reset in the middle of a count aborts it: after the reset edge `done` is 0 and `count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to count; held high until the result has been taken |
| operand | input | WIDTH (8) | Word whose 1 bits are counted |
| count | output | CNT_W (4) | Tally of 1 bits; valid while `done` is high |
| done | output | 1 | High when the tally is complete |

## Verification
A wrong shift or a wrong tally step shows up in `count` as soon as `done` rises. That happens at most WIDTH+4 clocks after `start`. A bad transition into the final state shows up in the latency of R4, so it is seen exactly, to the cycle, for each of the 256 words. Each word is run twice, once with the operand held steady and once with it scrambled after capture. A missed load or a missed clear of the tally is seen one edge into idle, through the zero `count` of R2 and R6.

// File: rtl/bitcount_pkg.sv
package bitcount_pkg;

  typedef enum logic [1:0] {
    BC_IDLE = 2'd0,
    BC_RUN  = 2'd1,
    BC_FIN  = 2'd2
  } bc_state_e;

  // Tally step: add one when the bit shifted out is set.
  function automatic logic [7:0] tally_step(input logic [7:0] cur, input logic lsb);
    return cur + {7'd0, lsb};
  endfunction

endpackage

// File: rtl/bitcount_sync.sv
module bitcount_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bitcount_ctrl.sv
module bitcount_ctrl
  import bitcount_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_s,
  input  logic opnd_zero,
  output logic ld_op,
  output logic sh_op,
  output logic done
);
  bc_state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= BC_IDLE;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    ld_op   = 1'b0;
    sh_op   = 1'b0;
    unique case (state_q)
      BC_IDLE: begin
        if (start_s) state_d = BC_RUN;
        else         ld_op   = 1'b1;
      end
      BC_RUN: begin
        if (opnd_zero) state_d = BC_FIN;
        else           sh_op   = 1'b1;
      end
      BC_FIN: begin
        if (!start_s) state_d = BC_IDLE;
      end
      default: state_d = BC_IDLE;
    endcase
  end

  assign done = (state_q == BC_FIN);
endmodule

// File: rtl/bitcount_datapath.sv
module bitcount_datapath
  import bitcount_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_op,
  input  logic             sh_op,
  input  logic [WIDTH-1:0] operand,
  output logic [WIDTH-1:0] opnd_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             opnd_zero
);
  logic [7:0] step_full;

  assign step_full = tally_step(8'(cnt_q), opnd_q[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_q <= '0;
      cnt_q  <= '0;
    end else if (ld_op) begin
      opnd_q <= operand;
      cnt_q  <= '0;
    end else if (sh_op) begin
      opnd_q <= opnd_q >> 1;
      cnt_q  <= step_full[CNT_W-1:0];
    end
  end

  assign opnd_zero = (opnd_q == '0);
endmodule

// File: rtl/bitcount_asmd.sv
module bitcount_asmd #(
  parameter int WIDTH = 8,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] operand,
  output logic [CNT_W-1:0] count,
  output logic             done
);
  logic             start_s;
  logic             ld_op;
  logic             sh_op;
  logic             opnd_zero;
  logic [WIDTH-1:0] opnd_q;

  bitcount_sync #(.STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (start),
    .q   (start_s)
  );

  bitcount_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_s   (start_s),
    .opnd_zero (opnd_zero),
    .ld_op     (ld_op),
    .sh_op     (sh_op),
    .done      (done)
  );

  bitcount_datapath #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ld_op     (ld_op),
    .sh_op     (sh_op),
    .operand   (operand),
    .opnd_q    (opnd_q),
    .cnt_q     (count),
    .opnd_zero (opnd_zero)
  );
endmodule

// File: rtl/bitcount_asmd_chk.sv
module bitcount_asmd_chk #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start_s,
  input logic             ld,
  input logic             sh,
  input logic [WIDTH-1:0] opnd,
  input logic [CNT_W-1:0] count,
  input logic             done
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!done && count == '0)); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst) ld |=> (count == '0)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) count <= CNT_W'(WIDTH)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    sh |=> (count == $past(count) || count == $past(count) + 1'b1)); // R3
  AST_DONE_ON_ZERO: assert property (@(posedge clk) disable iff (rst) $rose(done) |-> (opnd == '0)); // R4
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst) (done && start_s) |=> done); // R5
  AST_DONE_STABLE: assert property (@(posedge clk) disable iff (rst) (done && start_s) |=> $stable(count)); // R5
  AST_NO_LOAD_SHIFT: assert property (@(posedge clk) disable iff (rst) $onehot0({ld, sh, done})); // R7
endmodule

bind bitcount_asmd bitcount_asmd_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_s (start_s),
  .ld      (ld_op),
  .sh      (sh_op),
  .opnd    (opnd_q),
  .count   (count),
  .done    (done)
);

// File: tb/tb_bitcount_asmd.sv
module tb_bitcount_asmd;
  localparam int WIDTH = 8;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [WIDTH-1:0] operand = '0;
  logic [CNT_W-1:0] count;
  logic             done;

  int checks = 0;
  int errors = 0;

  bitcount_asmd #(.WIDTH(WIDTH)) dut (
    .clk(clk), .rst(rst), .start(start), .operand(operand), .count(count), .done(done)
  );

  always #5 clk = ~clk;

  function automatic int ones_of(input logic [WIDTH-1:0] w);
    int n = 0;
    for (int i = 0; i < WIDTH; i++) n += int'(w[i]);
    return n;
  endfunction

  function automatic int span_of(input logic [WIDTH-1:0] w);
    int s = 0;
    for (int i = 0; i < WIDTH; i++) if (w[i]) s = i + 1;
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run_word(input logic [WIDTH-1:0] w, input bit scramble);
    int n;
    operand = w;
    start = 1'b0;
    tick(); tick();
    check("R2 idle done", int'(done), 0);
    check("R2 idle count", int'(count), 0);
    start = 1'b1;
    n = 0;
    while (!done && n < 40) begin
      tick();
      n++;
      if (scramble && n == 3) operand = ~w ^ WIDTH'(n);
    end
    check("R4 latency", n, 4 + span_of(w));
    if (scramble) check("R7 count", int'(count), ones_of(w));
    else          check("R3 count", int'(count), ones_of(w));
    operand = ~operand;
    tick(); tick();
    check("R5 done held", int'(done), 1);
    check("R5 count held", int'(count), ones_of(w));
    start = 1'b0;
    tick(); tick(); tick();
    check("R6 done falls", int'(done), 0);
    tick();
    check("R6 count cleared", int'(count), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    tick(); tick(); tick();
    check("R1 reset done", int'(done), 0);
    check("R1 reset count", int'(count), 0);
    rst = 1'b0;
    tick();

    for (int w = 0; w < (1 << WIDTH); w++) run_word(WIDTH'(w), 1'b0);
    for (int w = 0; w < (1 << WIDTH); w++) run_word(WIDTH'(w), 1'b1);

    // R8: reset in the middle of counting a full word
    operand = '1;
    tick(); tick();
    start = 1'b1;
    repeat (6) tick();
    rst = 1'b1;
    tick();
    check("R8 abort done", int'(done), 0);
    check("R8 abort count", int'(count), 0);
    rst = 1'b0;
    start = 1'b0;
    repeat (4) tick();
    run_word(8'hA5, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule